// File: doc/BRIEF.md
# Serial Transmitter with Sixteenth-Step Stop Period

This block turns parallel characters into an asynchronous serial stream for one channel. It runs from a system clock and advances only on a one-cycle enable pulse at sixteen times the bit rate. The host supplies the rate enable. Each character has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit. The parity bit can be computed (even or odd) or forced to a fixed level. The character ends with a high stop period whose length is set in sixteenths of a bit.

A single holding register sits in front of the shift engine. The host may load the next character while the current one is still on the line, and that character then follows with no gap. Enable and disable commands gate the channel. An optional clear-to-send input can hold back the start of each character. Two status outputs tell the host when the holding register can be written and when the whole transmitter has gone quiet.

Top module: `serial_tx_fracstop`

## Requirements
- R1: After reset, `txd` is 1, `tx_enabled` is 0, `tx_ready` is 0 and `tx_empty` is 1.
- R2: A `cmd_enable` pulse sets `tx_enabled` from the next cycle, and a `cmd_disable` pulse clears it. When both are high in the same cycle, the disable wins.
- R3: A write (`wr_valid` high) is taken only when `tx_ready` is 1. `tx_ready` equals enabled AND holding register empty. A write while disabled, or while the holding register is full, has no effect on the register or on the line.
- R4: A character is a start bit of 16 ticks at 0, followed by the data bits sent least significant bit first at 16 ticks each. The `char_len` code picks the data bit count: 00=5, 01=6, 10=7, 11=8.
- R5: `par_mode` 00 adds a computed parity bit after the data. With `par_odd`=0 the total count of ones is even, and with `par_odd`=1 it is odd. `par_mode` 01 adds a parity bit equal to `par_odd`. `par_mode` 10 and 11 send no parity bit.
- R6: For 6, 7 or 8 data bits, a `stop_code` n in the range 0..7 gives a stop period of 9+n ticks at 1.
- R7: A `stop_code` n in the range 8..15 gives a stop period of 17+n ticks, for any character size.
- R8: For 5 data bits, a `stop_code` n in the range 0..7 gives a stop period of 17+n ticks, which is half a bit longer than R6.
- R9: `tx_empty` is 1 only when the holding register is empty and no character is in progress. While no character is in progress, `txd` is 1.
- R10: When `cts_gate_en` is 1 and `cts` is 0, no new character starts. A character already held starts once `cts` rises.
- R11: A disable during a character lets that character finish, including its full stop period. A character in the holding register stays there and is not sent until the channel is enabled again.
- R12: When a character is waiting in the holding register, its start bit begins directly at the end of the previous stop period, with no idle tick in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| cmd_enable | input | 1 | Enable command pulse |
| cmd_disable | input | 1 | Disable command pulse |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Character to load |
| char_len | input | 2 | Data bit count code (5 + value) |
| par_mode | input | 2 | Parity mode: computed, forced, none, none |
| par_odd | input | 1 | Odd parity select, or the forced parity level |
| stop_code | input | 4 | Stop period code in sixteenths of a bit |
| cts_gate_en | input | 1 | Makes each start wait for `cts` |
| cts | input | 1 | Clear-to-send, active high |
| txd | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Holding register can accept a write |
| tx_empty | output | 1 | Holding register empty and line idle |
| tx_enabled | output | 1 | Channel enabled state |

## Verification
The assertions watch, on every cycle, the command behaviour, the refusal of writes while disabled, the coupling between the status flags and line idleness, and the clear-to-send hold-off. Only the bench scenarios can show the exact tick length of each stop code for both short and 5-bit characters, the bit order and parity values, gapless back-to-back framing, and a disable that lets the running character complete while keeping the held one. The bench decodes these from the line, one sample per 16x tick.

// File: rtl/serial_tx_fracstop_pkg.sv
package serial_tx_fracstop_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_START = 3'd1,
        PH_DATA  = 3'd2,
        PH_PAR   = 3'd3,
        PH_STOP  = 3'd4
    } tx_phase_e;

    typedef enum logic [1:0] {
        PM_CALC  = 2'b00,
        PM_FORCE = 2'b01,
        PM_NONE  = 2'b10,
        PM_NONE2 = 2'b11
    } par_mode_e;

    // Parity bit for the given masked data: computed or forced level.
    function automatic logic parity_of(input logic red_xor, input logic [1:0] mode,
                                       input logic odd_sel);
        logic p;
        if (mode == PM_FORCE) p = odd_sel;
        else                  p = red_xor ^ odd_sel;
        return p;
    endfunction

    function automatic logic parity_on(input logic [1:0] mode);
        return (mode == PM_CALC) || (mode == PM_FORCE);
    endfunction

endpackage

// File: rtl/tx_cmd_hold.sv
module tx_cmd_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              enabled,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data
);

    typedef struct packed {
        logic              en;
        logic              full;
        logic [DATA_W-1:0] data;
    } hold_st_t;

    hold_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // disable has priority over enable
        if (cmd_disable)     st_d.en = 1'b0;
        else if (cmd_enable) st_d.en = 1'b1;
        if (take) st_d.full = 1'b0;
        // a write lands only while enabled and the register is free
        if (wr_valid && st_q.en && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enabled   = st_q.en;
    assign hold_full = st_q.full;
    assign hold_data = st_q.data;

endmodule

// File: rtl/tx_stop_calc.sv
module tx_stop_calc #(
    parameter int unsigned OVS = 16,
    parameter int unsigned SW  = 6
) (
    input  logic [3:0]    stop_code,
    input  logic          len5,
    output logic [SW-1:0] stop_ticks
);

    localparam int unsigned HALF = OVS / 2;
    localparam int unsigned STEP = OVS / 16;

    logic [SW-1:0] base_t;
    logic [SW-1:0] extra_t;
    logic [SW-1:0] frac_t;

    generate
        if (STEP == 1) begin : g_unit_step
            always_comb frac_t = SW'({1'b0, stop_code[2:0]}) + SW'(1);
        end else begin : g_scaled_step
            always_comb frac_t = SW'(STEP) * (SW'({1'b0, stop_code[2:0]}) + SW'(1));
        end
    endgenerate

    always_comb begin
        base_t     = stop_code[3] ? SW'(OVS + HALF) : SW'(HALF);
        extra_t    = (!stop_code[3] && len5) ? SW'(HALF) : '0;
        stop_ticks = base_t + extra_t + frac_t;
    end

endmodule

// File: rtl/tx_frame_engine.sv
module tx_frame_engine
    import serial_tx_fracstop_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16,
    parameter int unsigned SW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              launch_ok,
    input  logic [DATA_W-1:0] hold_data,
    input  logic [1:0]        char_len,
    input  logic [1:0]        par_mode,
    input  logic              par_odd,
    input  logic [SW-1:0]     stop_ticks,
    output logic              take,
    output logic              busy,
    output logic              txd
);

    localparam int unsigned IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [SW-1:0] LAST_TICK = SW'(OVS - 1);

    typedef struct packed {
        tx_phase_e         phase;
        logic [SW-1:0]     cnt;
        logic [IW-1:0]     idx;
        logic [IW-1:0]     last_idx;
        logic [DATA_W-1:0] shreg;
        logic              par_en;
        logic              par_val;
        logic [SW-1:0]     stop_len;
        logic              line;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic [DATA_W-1:0] masked;
    logic [IW-1:0]     nlast;
    logic              bit_end;
    logic              stop_end;
    logic              launch;

    always_comb begin
        nlast = IW'(4) + IW'(char_len);
        for (int i = 0; i < DATA_W; i++) begin
            masked[i] = hold_data[i] & (IW'(i) <= nlast);
        end
    end

    always_comb begin
        st_d     = st_q;
        take     = 1'b0;
        bit_end  = tick && (st_q.cnt == LAST_TICK);
        stop_end = (st_q.phase == PH_STOP) && tick && (st_q.cnt == st_q.stop_len - SW'(1));

        if (tick && st_q.phase != PH_IDLE) st_d.cnt = st_q.cnt + SW'(1);

        case (st_q.phase)
            PH_START: begin
                if (bit_end) begin
                    st_d.phase = PH_DATA;
                    st_d.cnt   = '0;
                    st_d.idx   = '0;
                    st_d.line  = st_q.shreg[0];
                    st_d.shreg = st_q.shreg >> 1;
                end
            end
            PH_DATA: begin
                if (bit_end) begin
                    st_d.cnt = '0;
                    if (st_q.idx == st_q.last_idx) begin
                        if (st_q.par_en) begin
                            st_d.phase = PH_PAR;
                            st_d.line  = st_q.par_val;
                        end else begin
                            st_d.phase = PH_STOP;
                            st_d.line  = 1'b1;
                        end
                    end else begin
                        st_d.idx   = st_q.idx + IW'(1);
                        st_d.line  = st_q.shreg[0];
                        st_d.shreg = st_q.shreg >> 1;
                    end
                end
            end
            PH_PAR: begin
                if (bit_end) begin
                    st_d.phase = PH_STOP;
                    st_d.cnt   = '0;
                    st_d.line  = 1'b1;
                end
            end
            PH_STOP: begin
                if (stop_end) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.line  = 1'b1;
                end
            end
            default: begin
                st_d.line = 1'b1;
                st_d.cnt  = '0;
            end
        endcase

        // next character starts from idle or straight out of a finishing stop
        launch = launch_ok && ((st_q.phase == PH_IDLE) || stop_end);
        if (launch) begin
            take          = 1'b1;
            st_d.phase    = PH_START;
            st_d.cnt      = '0;
            st_d.idx      = '0;
            st_d.line     = 1'b0;
            st_d.shreg    = masked;
            st_d.last_idx = nlast;
            st_d.par_en   = parity_on(par_mode);
            st_d.par_val  = parity_of(^masked, par_mode, par_odd);
            st_d.stop_len = stop_ticks;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.line  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase != PH_IDLE);
    assign txd  = st_q.line;

endmodule

// File: rtl/serial_tx_fracstop.sv
module serial_tx_fracstop #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              cmd_enable,
    input  logic              cmd_disable,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        char_len,
    input  logic [1:0]        par_mode,
    input  logic              par_odd,
    input  logic [3:0]        stop_code,
    input  logic              cts_gate_en,
    input  logic              cts,
    output logic              txd,
    output logic              tx_ready,
    output logic              tx_empty,
    output logic              tx_enabled
);

    localparam int unsigned SW = $clog2(2 * OVS + 1);

    logic              enabled;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              eng_busy;
    logic              launch_ok;
    logic [SW-1:0]     stop_ticks;

    tx_cmd_hold #(.DATA_W(DATA_W)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_enable (cmd_enable),
        .cmd_disable(cmd_disable),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .take       (take),
        .enabled    (enabled),
        .hold_full  (hold_full),
        .hold_data  (hold_data)
    );

    tx_stop_calc #(.OVS(OVS), .SW(SW)) u_stop (
        .stop_code (stop_code),
        .len5      (char_len == 2'b00),
        .stop_ticks(stop_ticks)
    );

    assign launch_ok = enabled && hold_full && (!cts_gate_en || cts);

    tx_frame_engine #(.DATA_W(DATA_W), .OVS(OVS), .SW(SW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .launch_ok (launch_ok),
        .hold_data (hold_data),
        .char_len  (char_len),
        .par_mode  (par_mode),
        .par_odd   (par_odd),
        .stop_ticks(stop_ticks),
        .take      (take),
        .busy      (eng_busy),
        .txd       (txd)
    );

    assign tx_ready   = enabled && !hold_full;
    assign tx_empty   = !hold_full && !eng_busy;
    assign tx_enabled = enabled;

endmodule

// File: rtl/tx_frac_checker.sv
module tx_frac_checker (
    input logic clk,
    input logic rst_n,
    input logic cmd_enable,
    input logic cmd_disable,
    input logic wr_valid,
    input logic cts_gate_en,
    input logic cts,
    input logic txd,
    input logic tx_ready,
    input logic tx_empty,
    input logic tx_enabled,
    input logic eng_busy
);

    p_enable_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_enable && !cmd_disable |=> tx_enabled);

    p_disable_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_disable |=> !tx_enabled);

    p_ready_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_enabled);

    p_no_load_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_enabled && tx_empty |=> tx_empty);

    p_write_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && tx_ready |=> !tx_ready);

    p_idle_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> txd);

    p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> !eng_busy);

    p_cts_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cts_gate_en && !cts && !eng_busy |=> !eng_busy);

endmodule

bind serial_tx_fracstop tx_frac_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_enable (cmd_enable),
    .cmd_disable(cmd_disable),
    .wr_valid   (wr_valid),
    .cts_gate_en(cts_gate_en),
    .cts        (cts),
    .txd        (txd),
    .tx_ready   (tx_ready),
    .tx_empty   (tx_empty),
    .tx_enabled (tx_enabled),
    .eng_busy   (eng_busy)
);

// File: tb/test_serial_tx_fracstop.sv
module test_serial_tx_fracstop;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       cmd_enable = 1'b0, cmd_disable = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] char_len = 2'b11, par_mode = 2'b10;
    logic       par_odd = 1'b0;
    logic [3:0] stop_code = '0;
    logic       cts_gate_en = 1'b0, cts = 1'b0;
    logic       txd, tx_ready, tx_empty, tx_enabled;

    always #4 clk = ~clk;

    // 16x enable every fourth clock, updated just after the rising edge
    logic [1:0] tdiv = '0;
    always @(posedge clk) begin
        tdiv   <= tdiv + 2'd1;
        tick16 <= (tdiv == 2'd2);
    end

    serial_tx_fracstop i_serial_tx_fracstop (
        .clk(clk), .rst_n(rst_n), .tick16(tick16),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .char_len(char_len), .par_mode(par_mode), .par_odd(par_odd),
        .stop_code(stop_code), .cts_gate_en(cts_gate_en), .cts(cts),
        .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_enabled(tx_enabled)
    );

    typedef struct packed {
        logic [9:0]  bits;
        logic [3:0]  nb;
        logic [5:0]  stop;
        logic [1:0]  nxt;   // 0: line goes quiet, 1: next start follows, 2: unchecked
        logic [15:0] dreq;
        logic [15:0] sreq;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic exp_t build(input logic [7:0] d, input logic [1:0] nxt);
        exp_t it;
        int   nd;
        logic [7:0] m;
        nd = 5 + int'(char_len);
        m  = d & 8'((1 << nd) - 1);
        it.bits = {2'b00, m};
        it.nb   = 4'(nd);
        it.dreq = "R4";
        if (par_mode == 2'b00) begin
            it.bits[nd] = (^m) ^ par_odd;
            it.nb = 4'(nd + 1);
            it.dreq = "R5";
        end else if (par_mode == 2'b01) begin
            it.bits[nd] = par_odd;
            it.nb = 4'(nd + 1);
            it.dreq = "R5";
        end
        if (stop_code >= 4'd8) begin
            it.stop = 6'(17 + int'(stop_code));
            it.sreq = "R7";
        end else if (char_len == 2'b00) begin
            it.stop = 6'(17 + int'(stop_code));
            it.sreq = "R8";
        end else begin
            it.stop = 6'(9 + int'(stop_code));
            it.sreq = "R6";
        end
        it.nxt = nxt;
        return it;
    endfunction

    task automatic send(input logic [7:0] d, input logic [1:0] nxt);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        sb.push_back(build(d, nxt));
        wr_data  = d;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        @(negedge clk);
        while (!tx_empty || sb.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse_cmd(input logic en, input logic dis);
        @(negedge clk);
        cmd_enable  = en;
        cmd_disable = dis;
        @(negedge clk);
        cmd_enable  = 1'b0;
        cmd_disable = 1'b0;
    endtask

    task automatic sample(output logic v, output logic e);
        do @(negedge clk); while (tick16 !== 1'b1);
        v = txd;
        e = tx_empty;
    endtask

    // monitor: decode the line one sample per tick and compare with the scoreboard
    initial begin
        logic v, e, b, same, ok;
        logic [9:0] got;
        bit   have;
        exp_t it;
        have = 1'b0;
        wait (rst_n);
        forever begin
            if (!have) begin
                sample(v, e);
                if (v !== 1'b0) continue;
            end
            have = 1'b0;
            if (sb.size() == 0) begin
                check(1'b0, "R3", "start bit with nothing queued", 0, 1);
                while (v !== 1'b1) sample(v, e);
                continue;
            end
            it = sb.pop_front();
            ok = 1'b1;
            for (int i = 0; i < 15; i++) begin
                sample(v, e);
                ok &= (v == 1'b0);
            end
            check(ok, "R4", "start bit length", int'(ok), 1);
            got  = '0;
            same = 1'b1;
            for (int k = 0; k < int'(it.nb); k++) begin
                sample(v, e);
                b = v;
                for (int j = 0; j < 15; j++) begin
                    sample(v, e);
                    same &= (v == b);
                end
                got[k] = b;
            end
            check(same && got == it.bits, string'(it.dreq), "frame bits",
                  int'(got), int'(it.bits));
            ok = 1'b1;
            for (int i = 0; i < int'(it.stop); i++) begin
                sample(v, e);
                ok &= (v == 1'b1) && (e == 1'b0);
            end
            check(ok, string'(it.sreq), "stop period held high and busy", int'(ok), 1);
            if (it.nxt == 2'd1) begin
                sample(v, e);
                check(v == 1'b0, "R12", "start right after stop", int'(v), 0);
                have = (v == 1'b0);
            end else if (it.nxt == 2'd0) begin
                sample(v, e);
                check(v == 1'b1 && e == 1'b1, string'(it.sreq), "stop ends on exact tick",
                      int'({v, e}), 3);
            end
        end
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R9", "watchdog expired", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic stay;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(txd == 1'b1 && tx_enabled == 1'b0 && tx_ready == 1'b0 && tx_empty == 1'b1,
              "R1", "reset outputs", int'({txd, tx_enabled, tx_ready, tx_empty}), 4'b1001);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: writes while disabled are ignored
        wr_data = 8'h5A; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_empty == 1'b1 && tx_ready == 1'b0 && txd == 1'b1, "R3",
              "write while disabled", int'({tx_empty, tx_ready, txd}), 3'b101);

        // R2 enable
        pulse_cmd(1'b1, 1'b0);
        check(tx_enabled == 1'b1 && tx_ready == 1'b1, "R2", "enable command",
              int'({tx_enabled, tx_ready}), 3);

        // R4, R6, R7: 8 data bits, every stop code
        char_len = 2'b11; par_mode = 2'b10;
        for (int c = 0; c < 16; c++) begin
            stop_code = 4'(c);
            send(8'(8'hA5 ^ c), 2'd0);
            wait_quiet();
        end

        // R8 and R7: 5 data bits, every stop code
        char_len = 2'b00;
        for (int c = 0; c < 16; c++) begin
            stop_code = 4'(c);
            send(8'(8'hF3 + c * 7), 2'd0);
            wait_quiet();
        end

        // R5 parity modes on 7 and 6 bit characters
        char_len = 2'b10; stop_code = 4'd3;
        par_mode = 2'b00; par_odd = 1'b0; send(8'h53, 2'd0); wait_quiet();
        par_mode = 2'b00; par_odd = 1'b1; send(8'h53, 2'd0); wait_quiet();
        par_mode = 2'b01; par_odd = 1'b0; send(8'h7F, 2'd0); wait_quiet();
        par_mode = 2'b01; par_odd = 1'b1; send(8'h00, 2'd0); wait_quiet();
        par_mode = 2'b11; par_odd = 1'b1; send(8'h2C, 2'd0); wait_quiet();
        char_len = 2'b01;
        par_mode = 2'b00; par_odd = 1'b1; send(8'hFF, 2'd0); wait_quiet();

        // R12 back-to-back, with an ignored write into a full register (R3)
        char_len = 2'b11; par_mode = 2'b00; par_odd = 1'b0; stop_code = 4'd9;
        send(8'h31, 2'd1);
        send(8'hC4, 2'd1);
        wr_data = 8'hEE; wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        check(tx_ready == 1'b0, "R3", "ready low while register full", int'(tx_ready), 0);
        send(8'h96, 2'd0);
        wait_quiet();

        // R10 clear-to-send gating
        par_mode = 2'b10; stop_code = 4'd0;
        cts_gate_en = 1'b1; cts = 1'b0;
        send(8'h3C, 2'd0);
        stay = 1'b1;
        repeat (300) begin
            @(negedge clk);
            stay &= (txd == 1'b1) && (tx_empty == 1'b0);
        end
        check(stay, "R10", "no start while cts low", int'(stay), 1);
        cts = 1'b1;
        wait_quiet();
        cts_gate_en = 1'b0;

        // R11 disable mid-character
        stop_code = 4'd12;
        send(8'h81, 2'd2);
        send(8'h7E, 2'd0);
        repeat (100) @(negedge clk);
        pulse_cmd(1'b0, 1'b1);
        check(tx_enabled == 1'b0 && tx_ready == 1'b0, "R11", "disable takes effect",
              int'({tx_enabled, tx_ready}), 0);
        repeat (1200) @(negedge clk);
        check(sb.size() == 1 && txd == 1'b1 && tx_empty == 1'b0, "R11",
              "held character kept while disabled", sb.size(), 1);
        pulse_cmd(1'b1, 1'b0);
        wait_quiet();

        // R2 both commands together: disable wins
        pulse_cmd(1'b1, 1'b1);
        check(tx_enabled == 1'b0, "R2", "disable wins over enable", int'(tx_enabled), 0);
        pulse_cmd(1'b1, 1'b0);
        check(tx_enabled == 1'b1, "R2", "re-enable", int'(tx_enabled), 1);

        repeat (50) @(negedge clk);
        check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule